// File: doc/BRIEF.md
# Manchester Configuration Readback Transmitter

This block sends one configuration register readback message over a single output wire. A requester offers a 4-bit register address and an 8-bit register value through a valid/ready handshake. The block builds a fixed 16-bit word and sends it after two start bits. Every bit is Manchester coded over two half-bit periods, and a programmable divider sets the length of each half-bit period.

The word holds the constant state vector 101b in bits 2..0, the data in bits 10..3, the address in bits 14..11, and an even parity bit in bit 15. The frame always has this layout. It uses parity as its only error check, with no CRC. No synchronisation pulse or auto-zero interval is inserted. The line is low while the block is idle. `busy` covers the whole frame, and a single-cycle `done` pulse marks its end.

Top module: `mcfg_tx`

## Requirements
- R1: After synchronous reset, `line_out`, `busy` and `done` are 0 and `req_ready` is 1. Whenever `busy` is 0, `line_out` is 0.
- R2: A request is accepted on a clock edge where `req_valid` is 1 and `busy` is 0, and `req_ready` equals the inverse of `busy`. Address, data and divider are captured at acceptance. Requests and input changes while busy have no effect on the frame being sent.
- R3: The frame starts with two start bits, sent as 1 and then 0.
- R4: Word bits 2..0 are the constant 101b, bits 10..3 are the register data (bit 3 = data LSB), and bits 14..11 are the address (bit 11 = address LSB).
- R5: Word bit 15 is set so that the 16 word bits contain an even number of ones.
- R6: The word goes out least significant bit first, with bit 0 right after the start bits and parity last, for 18 bits and 36 half-bits in total.
- R7: Manchester coding: a 1 is high in the first half-bit and low in the second, and a 0 is low then high.
- R8: Each half-bit lasts `half_div`+1 clock cycles, using the value captured at acceptance. Later changes to `half_div` do not alter the frame in progress.
- R9: `line_out` goes high in the cycle after the accepting edge, and `busy` is 1 from that cycle until the final half-bit ends. In the cycle after the final half-bit, `busy` is 0, `line_out` is 0 and `done` is 1 for exactly one cycle.
- R10: A request presented during the `done` cycle is accepted at once, and its frame follows with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_div | input | HDIV_W | Half-bit length minus one, in clock cycles |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | 4 | Register address to send |
| req_data | input | 8 | Register value to send |
| line_out | output | 1 | Manchester-coded serial output |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse after the last half-bit |

## Verification
The hardest situations to reach from the ports are the transitions at the frame boundaries. One is a request that arrives exactly in the `done` cycle and must start a new frame with no gap. Another is a divider change or a competing request partway through a frame. The bench chains frames by holding `req_valid` across the `done` cycle. It also changes `half_div` and offers conflicting requests at every half-bit of selected frames. Each sampled waveform is compared against a frame computed in the bench, across every data value and every address at several divider settings.

// File: rtl/mcfg_pkg.sv
package mcfg_pkg;
  localparam int ADDR_W     = 4;
  localparam int DATA_W     = 8;
  localparam int SV_W       = 3;
  localparam int WORD_W     = SV_W + DATA_W + ADDR_W + 1;
  localparam int FRAME_W    = WORD_W + 2;
  localparam int HALVES     = 2 * FRAME_W;
  localparam int HIDX_W     = $clog2(HALVES);
  localparam logic [SV_W-1:0] STATE_VEC = 3'b101;
  // frame bit 0 is sent first: start pattern 1 then 0
  localparam logic [1:0] START_PAT = 2'b01;

  function automatic logic [FRAME_W-1:0] build_frame(
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] data
  );
    logic [WORD_W-2:0] body;
    body = {addr, data, STATE_VEC};
    return {^body, body, START_PAT};
  endfunction

  // level of half-bit h: first half carries the bit, second its inverse
  function automatic logic half_level(
    input logic [FRAME_W-1:0] frame,
    input logic [HIDX_W-1:0]  h
  );
    logic b;
    b = frame[h[HIDX_W-1:1]];
    return h[0] ? ~b : b;
  endfunction
endpackage

// File: rtl/mcfg_tick.sv
module mcfg_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = en && (cnt == div);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (clear || tick) begin
      cnt <= '0;
    end else if (en) begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r8_count_in_range: assert property (@(posedge clk) disable iff (rst)
    en |-> (cnt <= div));
endmodule

// File: rtl/mcfg_seq.sv
module mcfg_seq
  import mcfg_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic [DIV_W-1:0]  div_in,
  input  logic              tick,
  output logic [DIV_W-1:0]  div_q,
  output logic              busy,
  output logic              line_out,
  output logic              done
);
  localparam logic [HIDX_W-1:0] LAST_HALF = HIDX_W'(HALVES - 1);

  logic [FRAME_W-1:0] frame_q;
  logic [HIDX_W-1:0]  hidx;
  logic [HIDX_W-1:0]  hnext;

  assign hnext = hidx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q  <= '0;
      div_q    <= '0;
      hidx     <= '0;
      busy     <= 1'b0;
      line_out <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        frame_q  <= build_frame(addr, data);
        div_q    <= div_in;
        hidx     <= '0;
        busy     <= 1'b1;
        line_out <= START_PAT[0];
      end else if (busy && tick) begin
        if (hidx == LAST_HALF) begin
          hidx     <= '0;
          busy     <= 1'b0;
          line_out <= 1'b0;
          done     <= 1'b1;
        end else begin
          hidx     <= hnext;
          line_out <= half_level(frame_q, hnext);
        end
      end
    end
  end

  a_r1_idle_low: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !line_out);
  a_r3_start_high: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> line_out);
  a_r2_frame_held: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(frame_q) && $stable(div_q)));
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !line_out));
endmodule

// File: rtl/mcfg_tx.sv
module mcfg_tx
  import mcfg_pkg::*;
#(
  parameter int HDIV_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HDIV_W-1:0] half_div,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              line_out,
  output logic              busy,
  output logic              done
);
  logic              accept;
  logic              tick;
  logic [HDIV_W-1:0] div_q;

  assign req_ready = ~busy;
  assign accept    = req_valid && ~busy;

  mcfg_tick #(.DIV_W(HDIV_W)) u_tick (
    .clk   (clk),
    .rst   (rst),
    .clear (accept),
    .en    (busy),
    .div   (div_q),
    .tick  (tick)
  );

  mcfg_seq #(.DIV_W(HDIV_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .addr     (req_addr),
    .data     (req_data),
    .div_in   (half_div),
    .tick     (tick),
    .div_q    (div_q),
    .busy     (busy),
    .line_out (line_out),
    .done     (done)
  );

  a_r2_ready_when_idle: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> busy);
endmodule

// File: tb/mcfg_tx_bench.sv
module mcfg_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HDIV_W     = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [HDIV_W-1:0] half_div = '0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [3:0]        req_addr = '0;
  logic [7:0]        req_data = '0;
  logic              line_out, busy, done;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcfg_tx #(.HDIV_W(HDIV_W)) u_mcfg_tx (
    .clk(clk), .rst(rst), .half_div(half_div),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data),
    .line_out(line_out), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected level of half-bit h, built from the requirements
  function automatic bit exp_half(input int h, input bit [3:0] a, input bit [7:0] d);
    bit [15:0] w;
    int ones;
    int j;
    bit b;
    w = 16'd5 | (16'(d) << 3) | (16'(a) << 11);
    ones = 0;
    for (int i = 0; i < 15; i++) ones += w[i];
    w[15] = ones[0];
    j = h / 2;
    if (j == 0) b = 1'b1;
    else if (j == 1) b = 1'b0;
    else b = w[j-2];
    return (h % 2 == 0) ? b : ~b;
  endfunction

  // caller is at a negedge; chain=1 leaves a fresh request pending at the done cycle
  task automatic run_frame(input bit [3:0] a, input bit [7:0] d, input int dv,
                           input bit disturb, input bit chain);
    int len;
    int bad;
    int badc;
    int badv;
    bit [15:0] got;
    bit [15:0] want;
    int ones;
    len = 36 * (dv + 1);
    half_div  = HDIV_W'(dv);
    req_addr  = a;
    req_data  = d;
    req_valid = 1'b1;
    @(negedge clk);
    chk(busy && !req_ready, "R9 busy after accept", busy, 1);
    if (!disturb) req_valid = 1'b0;
    bad = 0; badc = 0; badv = 0; got = '0;
    for (int c = 0; c < len; c++) begin
      if (c > 0) @(negedge clk);
      if (line_out !== exp_half(c / (dv + 1), a, d) || !busy || done) begin
        if (bad == 0) begin badc = c; badv = line_out; end
        bad++;
      end
      if (c % (2 * (dv + 1)) == 0 && c >= 4 * (dv + 1))
        got[(c / (2 * (dv + 1))) - 2] = line_out;
      if (disturb) begin
        half_div = HDIV_W'(dv ^ 3);
        req_addr = ~a;
        req_data = ~d;
        if (req_ready) bad++;
        if (c == len - 2) req_valid = 1'b0;
      end
    end
    chk(bad == 0, disturb ? "R2/R8 waveform under disturbance" : "R7/R8 waveform",
        badv, int'(exp_half(badc / (dv + 1), a, d)));
    want = 16'd5 | (16'(d) << 3) | (16'(a) << 11);
    ones = 0;
    for (int i = 0; i < 15; i++) ones += want[i];
    want[15] = ones[0];
    chk(got[2:0] == 3'b101, "R4 state vector", got[2:0], 5);
    chk({got[14:11], got[10:3]} == {a, d}, "R4/R6 addr+data", {got[14:11], got[10:3]}, {a, d});
    chk(got[15] == want[15] && ($countones(got) % 2 == 0), "R5 parity", got[15], want[15]);
    @(negedge clk);
    chk(done && !busy && !line_out && req_ready, "R9 done cycle", {done, busy, line_out}, 4);
    if (!chain) begin
      req_valid = 1'b0;
      @(negedge clk);
      chk(!done && !line_out && !busy, "R9 done single/idle low", {done, line_out}, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!line_out && !busy && !done && req_ready, "R1 reset state",
        {line_out, busy, done, req_ready}, 1);
    rst = 1'b0;
    @(negedge clk);
    chk(!line_out && req_ready, "R1 idle after reset", line_out, 0);
    // R3 first half-bit high in the cycle after acceptance
    for (int v = 0; v < 256; v++)
      run_frame(4'(v ^ (v >> 4)), 8'(v), 0, 1'b0, 1'b0);
    for (int dv = 1; dv <= 3; dv++)
      for (int a = 0; a < 16; a++)
        run_frame(4'(a), 8'(a * 37 + dv), dv, 1'b0, 1'b0);
    // R2 / R8: disturbance during a frame
    run_frame(4'hA, 8'h5C, 2, 1'b1, 1'b0);
    run_frame(4'h3, 8'hF0, 1, 1'b1, 1'b0);
    // R10: chained frames with no idle gap
    run_frame(4'h1, 8'h81, 1, 1'b0, 1'b1);
    run_frame(4'hF, 8'hFF, 0, 1'b0, 1'b1);
    run_frame(4'h0, 8'h00, 2, 1'b0, 1'b0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule